// File: doc/BRIEF.md
# Low-Frequency Clock Controller with Hitless Source Handover

This block owns the slow system clock and can feed it from either of two oscillators: an on-die RC oscillator or an external crystal oscillator. A control agent writes the desired source onto `src_sel`, then pulses `start_task`. The controller enables the chosen oscillator and waits out its startup time. Each startup time is modelled as a ready delay whose length in `sys_clk` cycles is a parameter. The controller then steers the oscillator onto `lfclk` through a glitch-free gate and raises `started` for one cycle.

When a start names a different source while the clock is already live, the current source keeps driving `lfclk` until the new oscillator is ready. The handover then turns the old gate off on a low phase of the old clock and the new gate on on a low phase of the new clock. No pulse is ever cut short. The only visible effect is one stretched low phase.

A stop task withdraws the global request, but the clock stays alive while any bit of `hold_req` is set. A stop that arrives before the status shows the clock running is ignored. `sys_off` forces the controller and both oscillators off at once. The status outputs report the running state and the source that is actually driving `lfclk`. They do not report the pending selection.

Top module: `lfclk_ctrl`

## Requirements
- R1: After reset `stat_running` is 0, `stat_src` is 0 (RC source), `osc_en` is 0, `started` is 0 and `lfclk` stays low.
- R2: A `start_task` pulse while off takes the source from `src_sel` (0 = RC, 1 = crystal), raises `osc_en` bit 0 for RC or bit 1 for crystal, and once startup completes `lfclk` equals that source clock.
- R3: A start naming another source while running leaves `lfclk`, `stat_src` and `stat_running` unchanged until the new oscillator is ready; only then does the output change over.
- R4: `lfclk` never glitches: every high phase is a full half period of one source, every low phase lasts at least the shorter source half period, and the two source gates are never open together.
- R5: `started` is a one-cycle pulse issued when the selected source drives `lfclk`; a start naming the source already driving gives `started` in the following cycle.
- R6: After a stop task, the clock keeps running while any `hold_req` bit is set; when all hold bits are clear and no start has re-requested it, the clock shuts down and `osc_en` returns to 0.
- R7: A `stop_task` issued while `stat_running` is 0 has no effect; the pending start still completes and the clock stays on afterwards.
- R8: While `sys_off` is high, from the next cycle on, `osc_en`, `stat_running` and `lfclk` are 0, and start tasks are ignored.
- R9: `started` is never given earlier than the configured startup cycle count of the target source after its start task.
- R10: `stat_src` reports the source currently driving `lfclk` and changes only in the cycle `started` pulses, after the handover completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Control clock for the state machine and status |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_clk | input | 1 | Free-running RC oscillator clock |
| xo_clk | input | 1 | Free-running crystal oscillator clock |
| src_sel | input | 1 | Source selection, 0 = RC, 1 = crystal |
| start_task | input | 1 | One-cycle start request |
| stop_task | input | 1 | One-cycle stop request (global request only) |
| sys_off | input | 1 | Forces the controller and oscillators off |
| hold_req | input | N_HOLD | Per-component requests that keep the clock alive |
| lfclk | output | 1 | Gated low-frequency clock |
| started | output | 1 | One-cycle pulse when the selected source drives `lfclk` |
| stat_running | output | 1 | Running state of the clock |
| stat_src | output | 1 | Source currently driving `lfclk` |
| osc_en | output | 2 | Oscillator enables, bit 0 RC, bit 1 crystal |

## Verification
Several results sit a fixed number of `sys_clk` edges after the stimulus. The `started` reply to a start for the already-active source, the drop of status and enables after `sys_off`, and the ignored start under `sys_off` are each one edge later. The bench samples these on the falling edge that directly follows, or several cycles later where the check is that nothing happened.

Startup and handover results depend on two asynchronous oscillator clocks. For these, the bench counts cycles from the start pulse to `started` and checks that the count is no smaller than the startup parameter and no larger than that parameter plus a bound covering a few source periods. While a switch is pending, the bench compares `lfclk` with the old source on every falling `sys_clk` edge. A monitor timestamps every `lfclk` edge to check the width of each high and low phase.

// File: rtl/lfclk_pkg.sv
package lfclk_pkg;
  localparam int NUM_SRC = 2;
  localparam logic SRC_RC = 1'b0;
  localparam logic SRC_XO = 1'b1;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_HAND  = 3'd2,
    ST_RUN   = 3'd3,
    ST_DRAIN = 3'd4
  } ctl_state_t;
endpackage

// File: rtl/lfclk_osc_timer.sv
// Startup model of one oscillator: ready after START_CYC enabled cycles.
module lfclk_osc_timer #(
  parameter int START_CYC = 19661
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic ready
);
  localparam int W = $clog2(START_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(START_CYC);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en)          cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = en && (cnt == LIMIT);

  // A freshly enabled oscillator is never reported ready at once.
  p_fresh_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> !ready);
endmodule

// File: rtl/lfclk_gate_cell.sv
// One leg of the glitch-free selector: two-flop handshake, low-phase enable.
module lfclk_gate_cell (
  input  logic sys_clk,
  input  logic src_clk,
  input  logic arst_n,
  input  logic want,
  input  logic other_gate,
  output logic gate,
  output logic gate_sys,
  output logic clk_part
);
  logic s1, s2, y1;

  always_ff @(posedge src_clk or negedge arst_n) begin
    if (!arst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= want & ~other_gate;
      s2 <= s1;
    end
  end

  // Enable changes only while the source clock is low.
  always_ff @(negedge src_clk or negedge arst_n) begin
    if (!arst_n) gate <= 1'b0;
    else         gate <= s2;
  end

  always_ff @(posedge sys_clk or negedge arst_n) begin
    if (!arst_n) begin
      y1       <= 1'b0;
      gate_sys <= 1'b0;
    end else begin
      y1       <= gate;
      gate_sys <= y1;
    end
  end

  assign clk_part = src_clk & gate;
endmodule

// File: rtl/lfclk_ctrl.sv
module lfclk_ctrl
  import lfclk_pkg::*;
#(
  parameter int RC_START_CYC = 19661,
  parameter int XO_START_CYC = 6553600,
  parameter int N_HOLD       = 2
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              rc_clk,
  input  logic              xo_clk,
  input  logic              src_sel,
  input  logic              start_task,
  input  logic              stop_task,
  input  logic              sys_off,
  input  logic [N_HOLD-1:0] hold_req,
  output logic              lfclk,
  output logic              started,
  output logic              stat_running,
  output logic              stat_src,
  output logic [1:0]        osc_en
);
  ctl_state_t         state;
  logic               target_src, active_src, want_src;
  logic               live, global_req, want_valid, kill_q;
  logic [NUM_SRC-1:0] src_clk, rdy, gate, gsync, part;
  logic               gate_rst_n;

  assign src_clk    = {xo_clk, rc_clk};
  assign gate_rst_n = rst_n & ~kill_q;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= sys_off;
  end

  // Oscillator enables derive from the controller state.
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      osc_en[i] = (((state == ST_WAIT) || (state == ST_HAND)) && (target_src == 1'(i)))
               || ((state != ST_OFF) && (live || (state == ST_DRAIN)) && (active_src == 1'(i)));
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    lfclk_osc_timer #(
      .START_CYC((i == 0) ? RC_START_CYC : XO_START_CYC)
    ) u_tmr (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .en    (osc_en[i]),
      .ready (rdy[i])
    );

    lfclk_gate_cell u_gate (
      .sys_clk    (sys_clk),
      .src_clk    (src_clk[i]),
      .arst_n     (gate_rst_n),
      .want       (want_valid && (want_src == 1'(i))),
      .other_gate (gate[NUM_SRC-1-i]),
      .gate       (gate[i]),
      .gate_sys   (gsync[i]),
      .clk_part   (part[i])
    );
  end

  assign lfclk = |part;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      target_src <= SRC_RC;
      active_src <= SRC_RC;
      want_src   <= SRC_RC;
      want_valid <= 1'b0;
      live       <= 1'b0;
      global_req <= 1'b0;
      started    <= 1'b0;
    end else begin
      started <= 1'b0;
      if (sys_off) begin
        state      <= ST_OFF;
        live       <= 1'b0;
        global_req <= 1'b0;
        want_valid <= 1'b0;
      end else begin
        unique case (state)
          ST_OFF: if (start_task) begin
            target_src <= src_sel;
            global_req <= 1'b1;
            state      <= ST_WAIT;
          end
          ST_WAIT: begin
            if (stop_task && live) global_req <= 1'b0;
            if (start_task) begin
              global_req <= 1'b1;
              if (live && (src_sel == active_src)) begin
                target_src <= src_sel;
                started    <= 1'b1;
                state      <= ST_RUN;
              end else begin
                target_src <= src_sel;
              end
            end else if (rdy[target_src]) begin
              want_valid <= 1'b1;
              want_src   <= target_src;
              state      <= ST_HAND;
            end
          end
          ST_HAND: begin
            if (stop_task && live) global_req <= 1'b0;
            if (gsync[target_src] && !gsync[~target_src]) begin
              active_src <= target_src;
              live       <= 1'b1;
              started    <= 1'b1;
              state      <= ST_RUN;
            end
          end
          ST_RUN: begin
            if (start_task) begin
              global_req <= 1'b1;
              if (src_sel == active_src) begin
                started <= 1'b1;
              end else begin
                target_src <= src_sel;
                state      <= ST_WAIT;
              end
            end else if (stop_task) begin
              global_req <= 1'b0;
            end else if (!global_req && (hold_req == '0)) begin
              want_valid <= 1'b0;
              live       <= 1'b0;
              state      <= ST_DRAIN;
            end
          end
          ST_DRAIN: if (gsync == '0) state <= ST_OFF;
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  assign stat_running = live;
  assign stat_src     = active_src;

  p_one_gate_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !(gate[0] && gate[1]));
  p_started_live_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    started |-> (live && osc_en[active_src]));
  p_hold_keeps_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (live && (hold_req != '0) && !sys_off) |=> live);
  p_early_stop_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (stop_task && !live && !sys_off && ((state == ST_WAIT) || (state == ST_HAND)))
      |=> global_req);
  p_off_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    sys_off |=> ((state == ST_OFF) && !live && (osc_en == 2'b00)));
  p_src_moves_r10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !$stable(active_src) |-> started);
endmodule

// File: tb/tb_lfclk_ctrl.sv
`timescale 1ns/1ps
module tb_lfclk_ctrl;
  localparam int RC_CYC = 30;
  localparam int XO_CYC = 60;
  localparam int SLACK  = 150;

  logic sys_clk = 1'b0, rc_clk = 1'b0, xo_clk = 1'b0;
  logic rst_n = 1'b0, src_sel = 1'b0, start_task = 1'b0, stop_task = 1'b0, sys_off = 1'b0;
  logic [1:0] hold_req = 2'b00;
  logic lfclk, started, stat_running, stat_src;
  logic [1:0] osc_en;

  int tests = 0, fails = 0, glitches = 0;
  bit done = 1'b0;

  always #2  sys_clk = ~sys_clk;
  always #20 rc_clk  = ~rc_clk;
  always #28 xo_clk  = ~xo_clk;

  lfclk_ctrl #(.RC_START_CYC(RC_CYC), .XO_START_CYC(XO_CYC), .N_HOLD(2)) dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .rc_clk(rc_clk), .xo_clk(xo_clk),
    .src_sel(src_sel), .start_task(start_task), .stop_task(stop_task),
    .sys_off(sys_off), .hold_req(hold_req), .lfclk(lfclk), .started(started),
    .stat_running(stat_running), .stat_src(stat_src), .osc_en(osc_en));

  // R4 phase-width monitor
  realtime t_rise = 0.0, t_fall = 0.0;
  bit seen_fall = 1'b0;
  always @(posedge lfclk) begin
    if (seen_fall && ($realtime - t_fall < 19.9)) glitches++;
    t_rise = $realtime;
  end
  always @(negedge lfclk) begin
    realtime w;
    w = $realtime - t_rise;
    if (!((w > 19.9 && w < 20.1) || (w > 27.9 && w < 28.1))) glitches++;
    t_fall = $realtime;
    seen_fall = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic sel);
    @(negedge sys_clk); src_sel = sel; start_task = 1'b1;
    @(negedge sys_clk); start_task = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge sys_clk); stop_task = 1'b1;
    @(negedge sys_clk); stop_task = 1'b0;
  endtask

  // cycles counted from the cycle after the start pulse was applied
  task automatic wait_started(output int cyc);
    cyc = 1;
    while (!started && cyc < 2000) begin
      @(negedge sys_clk); cyc++;
    end
  endtask

  task automatic follow(input logic which, input int n, input string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge sys_clk);
      if (lfclk !== (which ? xo_clk : rc_clk)) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc, bad;
    repeat (5) @(negedge sys_clk);
    rst_n = 1'b1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge sys_clk);
      if (lfclk || started || stat_running || osc_en != 2'b00) bad++;
    end
    check(bad == 0 && stat_src == 1'b0, "R1 reset state", bad, 0);

    // R2/R9/R5 start on RC from off
    pulse_start(1'b0);
    check(osc_en == 2'b01, "R2 RC enable", osc_en, 1);
    wait_started(cyc);
    check(cyc >= RC_CYC, "R9 RC startup not early", cyc, RC_CYC);
    check(cyc <= RC_CYC + SLACK, "R5 RC started bound", cyc, RC_CYC + SLACK);
    @(negedge sys_clk);
    check(!started, "R5 started single pulse", started, 0);
    check(stat_running && stat_src == 1'b0, "R10 status RC", stat_src, 0);
    follow(1'b0, 100, "R2 lfclk follows RC");

    // R3 switch to crystal while running
    pulse_start(1'b1);
    bad = 0;
    for (int k = 0; k < XO_CYC - 4; k++) begin
      @(negedge sys_clk);
      if (lfclk !== rc_clk || stat_src != 1'b0 || !stat_running || started) bad++;
    end
    check(bad == 0, "R3 old source holds during switch", bad, 0);
    check(osc_en == 2'b11, "R3 both oscillators on", osc_en, 3);
    wait_started(cyc);
    check(cyc >= XO_CYC && cyc <= XO_CYC + SLACK, "R9 crystal handover time", cyc, XO_CYC);
    @(negedge sys_clk);
    check(stat_src == 1'b1 && stat_running, "R10 status crystal", stat_src, 1);
    follow(1'b1, 100, "R3 lfclk follows crystal");
    check(osc_en == 2'b10, "R3 old oscillator released", osc_en, 2);

    // R5 start for the source already driving
    @(negedge sys_clk); src_sel = 1'b1; start_task = 1'b1;
    @(negedge sys_clk); start_task = 1'b0;
    check(started == 1'b1, "R5 same-source started next cycle", started, 1);

    // R6 hold keeps clock through stop
    hold_req = 2'b10;
    pulse_stop();
    repeat (50) @(negedge sys_clk);
    check(stat_running == 1'b1, "R6 hold keeps running", stat_running, 1);
    follow(1'b1, 50, "R6 clock alive under hold");
    hold_req = 2'b00;
    repeat (3) @(negedge sys_clk);
    check(stat_running == 1'b0, "R6 shutdown after hold drop", stat_running, 0);
    repeat (80) @(negedge sys_clk);
    check(osc_en == 2'b00, "R6 oscillators off", osc_en, 0);
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge sys_clk);
      if (lfclk) bad++;
    end
    check(bad == 0, "R6 lfclk quiet after shutdown", bad, 0);

    // R7 early stop ignored
    pulse_stop();
    check(osc_en == 2'b00 && !stat_running, "R7 stop while off", osc_en, 0);
    pulse_start(1'b0);
    repeat (4) @(negedge sys_clk);
    pulse_stop();
    wait_started(cyc);
    check(started == 1'b1, "R7 start completes after early stop", started, 1);
    repeat (20) @(negedge sys_clk);
    check(stat_running == 1'b1, "R7 clock stays on", stat_running, 1);

    // R8 system off
    @(negedge sys_clk); sys_off = 1'b1;
    @(negedge sys_clk);
    check(osc_en == 2'b00 && !stat_running, "R8 off next cycle", {stat_running, osc_en}, 0);
    pulse_start(1'b1);
    repeat (10) @(negedge sys_clk);
    check(osc_en == 2'b00 && !stat_running, "R8 start ignored while off", osc_en, 0);
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge sys_clk);
      if (lfclk) bad++;
    end
    check(bad == 0, "R8 lfclk low while off", bad, 0);
    @(negedge sys_clk); sys_off = 1'b0;
    repeat (3) @(negedge sys_clk);
    pulse_start(1'b1);
    wait_started(cyc);
    @(negedge sys_clk);
    check(stat_running && stat_src == 1'b1, "R2 restart on crystal", stat_src, 1);
    follow(1'b1, 60, "R2 lfclk follows crystal after restart");

    check(glitches == 0, "R4 no glitch on lfclk", glitches, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule